// File: doc/BRIEF.md
# Privileged Model Register Read Unit

This block carries out the read of a model-specific configuration register for a simple processor pipeline. Each cycle it may accept one decoded request: the two opcode bytes, a lock-prefix flag, the current privilege level, the operating mode and the full 64-bit RCX value. The register index is taken from RCX, looked up in a small internal table, and the 64-bit contents are returned split across the RDX and RAX result registers. If the request breaks a mode, privilege, prefix or index rule, a fault vector and an error code are signalled instead.

The table has a fixed number of slots. Each slot holds a 32-bit index, a 64-bit value and a mask of implemented bits, and all of them are loaded through a simple write port. A lookup and its fault decision finish in one cycle. The result or the fault is registered and shows on the outputs for exactly one cycle after the request edge.

Top module: `priv_reg_reader`

## Requirements
- R1: A request acts only when its opcode equals 16'h0F32 (first byte 0x0F in bits 15:8, second byte 0x32 in bits 7:0). Any other opcode raises no output pulse and leaves raxOut and rdxOut unchanged.
- R2: The table is searched with reqRcx[31:0] only. reqRcx[63:32] has no effect on hit, miss or data.
- R3: On a successful read, one cycle after the request edge, resValid pulses and the result is loaded: rdxOut[31:0] gets bits 63:32 of the slot value and raxOut[31:0] gets bits 31:0.
- R4: After a successful read, bits 63:32 of both raxOut and rdxOut are zero.
- R5: Modes are encoded as reqMode 0=real, 1=protected, 2=compatibility, 3=virtual-8086, 4=64-bit, and 5..7 behave as protected. With reqLock set in any mode other than virtual-8086, an invalid-opcode fault (fltVector 6) is raised.
- R6: In protected, compatibility and 64-bit mode, a reqCpl other than 0 raises a general protection fault (fltVector 13, fltCode 0). Real mode accepts any reqCpl.
- R7: In virtual-8086 mode every request raises a general protection fault (fltVector 13, fltCode 0), whatever the lock flag and privilege level are.
- R8: An index that matches no written slot raises a general protection fault (fltVector 13) in every mode, real mode included.
- R9: Faults are ranked in this order: virtual-8086, then lock-prefix, then privilege, then missing index. The highest-ranked rule that applies sets the vector.
- R10: A fault pulses fltValid for one cycle and leaves raxOut and rdxOut unchanged. resValid and fltValid are never high together, and each pulses only in the cycle after an accepted request.
- R11: The table has 8 slots and all of them are empty after reset. A write (tblWrEn, tblWrSlot) stores the index, the value ANDed with the mask, and sets the slot valid. Value bits outside the mask read back as zero. When two valid slots hold the same index, the lower-numbered slot wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| reqOpcode | input | 16 | Opcode bytes, first byte in bits 15:8 |
| reqLock | input | 1 | Lock prefix present |
| reqCpl | input | 2 | Current privilege level |
| reqMode | input | 3 | Operating mode code |
| reqRcx | input | 64 | RCX value; low half is the index |
| tblWrEn | input | 1 | Table slot write strobe |
| tblWrSlot | input | 3 | Slot number to write |
| tblWrIndex | input | 32 | Register index for the slot |
| tblWrValue | input | 64 | Register contents for the slot |
| tblWrMask | input | 64 | Implemented-bit mask for the slot |
| resValid | output | 1 | One-cycle pulse: read completed |
| raxOut | output | 64 | RAX result register |
| rdxOut | output | 64 | RDX result register |
| fltValid | output | 1 | One-cycle pulse: fault raised |
| fltVector | output | 8 | Fault vector (6 invalid opcode, 13 protection) |
| fltCode | output | 16 | Fault error code (always 0) |

## Verification
The read path is run with a full-width value so that a swap or shift of the halves shows up. A value stored under a narrow mask shows whether masking is applied, and a duplicate index in a higher slot shows which slot wins. The same index is sent with different upper RCX bits to check that only the low half selects the slot. For the faults, requests that break several rules at once (lock with a bad privilege level and a missing index, virtual-8086 with lock) show the ranking. Each fault is followed by a read-out of raxOut and rdxOut to show they were not disturbed. A wrong opcode and the cycle after a pulse confirm that no output is produced by accident.

// File: rtl/prr_pkg.sv
package prr_pkg;
  localparam int IDX_W   = 32;
  localparam int VAL_W   = 64;
  localparam int HALF_W  = VAL_W / 2;
  localparam int ENTRIES = 8;
  localparam int SLOT_W  = $clog2(ENTRIES);

  localparam logic [15:0] OPC_READ = 16'h0F32;
  localparam logic [7:0]  VEC_UD   = 8'd6;
  localparam logic [7:0]  VEC_GP   = 8'd13;

  typedef enum logic [2:0] {
    MODE_REAL   = 3'd0,
    MODE_PROT   = 3'd1,
    MODE_COMPAT = 3'd2,
    MODE_V86    = 3'd3,
    MODE_LONG   = 3'd4
  } mode_e;

  typedef struct packed {
    logic load;
    logic faultUd;
    logic faultGp;
  } strobe_t;
endpackage

// File: rtl/prr_table.sv
module prr_table
  import prr_pkg::*;
#(
  parameter int N = ENTRIES,
  parameter int SW = SLOT_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [SW-1:0]    wrSlot,
  input  logic [IDX_W-1:0] wrIndex,
  input  logic [VAL_W-1:0] wrValue,
  input  logic [VAL_W-1:0] wrMask,
  input  logic [IDX_W-1:0] key,
  output logic             hit,
  output logic [VAL_W-1:0] hitVal
);
  logic [IDX_W-1:0] slotIdx [N];
  logic [VAL_W-1:0] slotVal [N];
  logic [N-1:0]     slotVld;

  for (genvar g = 0; g < N; g++) begin : gSlot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotVld[g] <= 1'b0;
        slotIdx[g] <= '0;
        slotVal[g] <= '0;
      end else if (wrEn && wrSlot == SW'(g)) begin
        slotVld[g] <= 1'b1;
        slotIdx[g] <= wrIndex;
        slotVal[g] <= wrValue & wrMask;
      end
    end
  end

  // scan from the top so the lowest matching slot is the last to win
  always_comb begin
    hit    = 1'b0;
    hitVal = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (slotVld[i] && slotIdx[i] == key) begin
        hit    = 1'b1;
        hitVal = slotVal[i];
      end
    end
  end
endmodule

// File: rtl/prr_ctrl.sv
module prr_ctrl
  import prr_pkg::*;
(
  input  logic        reqValid,
  input  logic [15:0] reqOpcode,
  input  logic        reqLock,
  input  logic [1:0]  reqCpl,
  input  logic [2:0]  reqMode,
  input  logic        hit,
  output strobe_t     st
);
  logic opOk;
  logic isV86;
  logic isReal;

  assign opOk   = (reqOpcode == OPC_READ);
  assign isV86  = (reqMode == MODE_V86);
  assign isReal = (reqMode == MODE_REAL);

  always_comb begin
    st = '0;
    if (reqValid && opOk) begin
      if (isV86)                      st.faultGp = 1'b1;
      else if (reqLock)               st.faultUd = 1'b1;
      else if (!isReal && reqCpl != 2'd0) st.faultGp = 1'b1;
      else if (!hit)                  st.faultGp = 1'b1;
      else                            st.load    = 1'b1;
    end
  end
endmodule

// File: rtl/prr_datapath.sv
module prr_datapath
  import prr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          st,
  input  logic [VAL_W-1:0] hitVal,
  output logic             resValid,
  output logic [VAL_W-1:0] raxOut,
  output logic [VAL_W-1:0] rdxOut,
  output logic             fltValid,
  output logic [7:0]       fltVector,
  output logic [15:0]      fltCode
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid  <= 1'b0;
      fltValid  <= 1'b0;
      raxOut    <= '0;
      rdxOut    <= '0;
      fltVector <= '0;
      fltCode   <= '0;
    end else begin
      resValid <= st.load;
      fltValid <= st.faultUd | st.faultGp;
      if (st.load) begin
        raxOut <= {{HALF_W{1'b0}}, hitVal[HALF_W-1:0]};
        rdxOut <= {{HALF_W{1'b0}}, hitVal[VAL_W-1:HALF_W]};
      end
      if (st.faultUd || st.faultGp) begin
        fltVector <= st.faultUd ? VEC_UD : VEC_GP;
        fltCode   <= '0;
      end
    end
  end
endmodule

// File: rtl/priv_reg_reader.sv
module priv_reg_reader
  import prr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [15:0] reqOpcode,
  input  logic        reqLock,
  input  logic [1:0]  reqCpl,
  input  logic [2:0]  reqMode,
  input  logic [63:0] reqRcx,
  input  logic        tblWrEn,
  input  logic [2:0]  tblWrSlot,
  input  logic [31:0] tblWrIndex,
  input  logic [63:0] tblWrValue,
  input  logic [63:0] tblWrMask,
  output logic        resValid,
  output logic [63:0] raxOut,
  output logic [63:0] rdxOut,
  output logic        fltValid,
  output logic [7:0]  fltVector,
  output logic [15:0] fltCode
);
  logic             hit;
  logic [VAL_W-1:0] hitVal;
  strobe_t          st;
  logic             unusedRcxHi;

  assign unusedRcxHi = ^reqRcx[63:IDX_W];

  prr_table uTable (
    .clk(clk), .rstN(rstN),
    .wrEn(tblWrEn), .wrSlot(tblWrSlot), .wrIndex(tblWrIndex),
    .wrValue(tblWrValue), .wrMask(tblWrMask),
    .key(reqRcx[IDX_W-1:0]), .hit(hit), .hitVal(hitVal)
  );

  prr_ctrl uCtrl (
    .reqValid(reqValid), .reqOpcode(reqOpcode), .reqLock(reqLock),
    .reqCpl(reqCpl), .reqMode(reqMode), .hit(hit), .st(st)
  );

  prr_datapath uDp (
    .clk(clk), .rstN(rstN), .st(st), .hitVal(hitVal),
    .resValid(resValid), .raxOut(raxOut), .rdxOut(rdxOut),
    .fltValid(fltValid), .fltVector(fltVector), .fltCode(fltCode)
  );
endmodule

// File: rtl/prr_checker.sv
module prr_checker (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic [15:0] reqOpcode,
  input logic        reqLock,
  input logic [1:0]  reqCpl,
  input logic [2:0]  reqMode,
  input logic        resValid,
  input logic [63:0] raxOut,
  input logic [63:0] rdxOut,
  input logic        fltValid,
  input logic [7:0]  fltVector
);
  logic accepted;
  assign accepted = reqValid && reqOpcode == 16'h0F32;

  // R10
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(resValid && fltValid));

  // R10
  pulse_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resValid || fltValid) |-> $past(accepted));

  // R10
  flt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    fltValid |-> ($stable(raxOut) && $stable(rdxOut)));

  // R5
  vec_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    fltValid |-> (fltVector == 8'd6 || fltVector == 8'd13));

  // R7
  v86_gp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && reqMode == 3'd3) |=> (fltValid && fltVector == 8'd13));

  // R5
  lock_ud_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && reqLock && reqMode != 3'd3) |=> (fltValid && fltVector == 8'd6));

  // R6
  cpl_gp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && !reqLock && reqMode != 3'd0 && reqCpl != 2'd0)
      |=> (fltValid && fltVector == 8'd13));

  // R4
  hi_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (raxOut[63:32] == 32'd0 && rdxOut[63:32] == 32'd0));
endmodule

bind priv_reg_reader prr_checker uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOpcode(reqOpcode),
  .reqLock(reqLock), .reqCpl(reqCpl), .reqMode(reqMode),
  .resValid(resValid), .raxOut(raxOut), .rdxOut(rdxOut),
  .fltValid(fltValid), .fltVector(fltVector)
);

// File: tb/tb_priv_reg_reader.sv
`timescale 1ns/1ps
module tb_priv_reg_reader;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [15:0] reqOpcode = '0;
  logic        reqLock = 1'b0;
  logic [1:0]  reqCpl = '0;
  logic [2:0]  reqMode = '0;
  logic [63:0] reqRcx = '0;
  logic        tblWrEn = 1'b0;
  logic [2:0]  tblWrSlot = '0;
  logic [31:0] tblWrIndex = '0;
  logic [63:0] tblWrValue = '0;
  logic [63:0] tblWrMask = '0;
  logic        resValid;
  logic [63:0] raxOut;
  logic [63:0] rdxOut;
  logic        fltValid;
  logic [7:0]  fltVector;
  logic [15:0] fltCode;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  priv_reg_reader dut (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrSlot(logic [2:0] s, logic [31:0] idx, logic [63:0] v, logic [63:0] m);
    @(negedge clk);
    tblWrEn = 1'b1; tblWrSlot = s; tblWrIndex = idx; tblWrValue = v; tblWrMask = m;
    @(negedge clk);
    tblWrEn = 1'b0;
  endtask

  // drive at a falling edge; results are visible at the next falling edge
  task automatic doReq(logic [15:0] op, logic lk, logic [1:0] cpl, logic [2:0] md, logic [63:0] rcx);
    @(negedge clk);
    reqValid = 1'b1; reqOpcode = op; reqLock = lk; reqCpl = cpl; reqMode = md; reqRcx = rcx;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic expOk(string req, logic [63:0] rax, logic [63:0] rdx);
    chk({req, " resValid"}, {63'd0, resValid}, 64'd1);
    chk({req, " fltValid"}, {63'd0, fltValid}, 64'd0);
    chk({req, " rax"}, raxOut, rax);
    chk({req, " rdx"}, rdxOut, rdx);
  endtask

  task automatic expFlt(string req, logic [7:0] vec, logic [63:0] rax, logic [63:0] rdx);
    chk({req, " fltValid"}, {63'd0, fltValid}, 64'd1);
    chk({req, " resValid"}, {63'd0, resValid}, 64'd0);
    chk({req, " vector"}, {56'd0, fltVector}, {56'd0, vec});
    chk({req, " code"}, {48'd0, fltCode}, 64'd0);
    chk({req, " rax held"}, raxOut, rax);
    chk({req, " rdx held"}, rdxOut, rdx);
  endtask

  task automatic tReset();
    chk("R11 reset resValid", {63'd0, resValid}, 64'd0);
    chk("R11 reset fltValid", {63'd0, fltValid}, 64'd0);
    chk("R11 reset rax", raxOut, 64'd0);
    doReq(16'h0F32, 1'b0, 2'd0, 3'd1, 64'h10);
    expFlt("R11 empty table miss", 8'd13, 64'd0, 64'd0);
  endtask

  task automatic tBasic();
    doReq(16'h0F32, 1'b0, 2'd0, 3'd1, 64'h10);
    expOk("R3 protected read", 64'h55667788, 64'h11223344);
    @(negedge clk);
    chk("R10 one-cycle pulse", {63'd0, resValid}, 64'd0);
  endtask

  task automatic tMaskAndHigh();
    doReq(16'h0F32, 1'b0, 2'd0, 3'd4, 64'hABCD_0000_C000_0080);
    expOk("R2 R4 R11 masked 64-bit read", 64'h0000_0FFF, 64'h0);
  endtask

  task automatic tDupAndReal();
    doReq(16'h0F32, 1'b0, 2'd3, 3'd0, 64'hFFFF_FFFF_0000_0010);
    expOk("R6 R11 real mode cpl3 lowest slot", 64'h55667788, 64'h11223344);
    doReq(16'h0F32, 1'b0, 2'd0, 3'd2, 64'h20);
    expOk("R3 compat read", 64'h89AB_CDEF, 64'h0123_4567);
  endtask

  task automatic tFaults();
    doReq(16'h0F32, 1'b0, 2'd3, 3'd1, 64'h20);
    expFlt("R6 protected cpl3", 8'd13, 64'h89AB_CDEF, 64'h0123_4567);
    doReq(16'h0F32, 1'b0, 2'd1, 3'd2, 64'h20);
    expFlt("R6 compat cpl1", 8'd13, 64'h89AB_CDEF, 64'h0123_4567);
    doReq(16'h0F32, 1'b1, 2'd0, 3'd3, 64'h20);
    expFlt("R7 R9 v86 with lock", 8'd13, 64'h89AB_CDEF, 64'h0123_4567);
    doReq(16'h0F32, 1'b1, 2'd3, 3'd1, 64'h99);
    expFlt("R5 R9 lock beats cpl and miss", 8'd6, 64'h89AB_CDEF, 64'h0123_4567);
    doReq(16'h0F32, 1'b1, 2'd0, 3'd0, 64'h20);
    expFlt("R5 lock in real mode", 8'd6, 64'h89AB_CDEF, 64'h0123_4567);
    doReq(16'h0F32, 1'b0, 2'd0, 3'd4, 64'h11);
    expFlt("R8 miss in 64-bit", 8'd13, 64'h89AB_CDEF, 64'h0123_4567);
    doReq(16'h0F32, 1'b0, 2'd3, 3'd0, 64'h0000_0010_0000_0000);
    expFlt("R2 R8 upper bits do not select", 8'd13, 64'h89AB_CDEF, 64'h0123_4567);
  endtask

  task automatic tBadOpcode();
    doReq(16'h0F30, 1'b0, 2'd0, 3'd1, 64'h10);
    chk("R1 wrong opcode resValid", {63'd0, resValid}, 64'd0);
    chk("R1 wrong opcode fltValid", {63'd0, fltValid}, 64'd0);
    chk("R1 wrong opcode rax held", raxOut, 64'h89AB_CDEF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    wrSlot(3'd0, 32'h10, 64'h1122_3344_5566_7788, {64{1'b1}});
    wrSlot(3'd1, 32'hC000_0080, {64{1'b1}}, 64'h0FFF);
    wrSlot(3'd2, 32'h10, 64'hDEAD_BEEF_DEAD_BEEF, {64{1'b1}});
    wrSlot(3'd7, 32'h20, 64'h0123_4567_89AB_CDEF, {64{1'b1}});
    tBasic();
    tMaskAndHigh();
    tDupAndReal();
    tFaults();
    tBadOpcode();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule